// File: doc/BRIEF.md
# Two-Channel DAC Conversion Sequencer

This block sequences a two-channel digital-to-analog converter cell. Conversion words come in on a valid/ready stream. Each word carries a 12-bit code and a channel tag. The words wait in a four-entry queue and are converted strictly in arrival order, each on its own channel. While there is nothing to convert, the cell is kept powered down. Any pending work powers it up. After a programmed start-up wait, the block issues one-cycle start strobes, one conversion after another. It drops power again once the work runs out.

In the normal timing mode, each conversion ends when the cell reports end-of-cycle. In the max-speed timing mode, an internal counter ends each conversion two cycles earlier, and the end-of-conversion flag then trails the cell by two extra cycles. A fast wake-up option holds the cell in a light standby state while it is asleep. Software programs the start-up count for that case. Each channel remembers the last code it converted. When a programmable refresh period expires, the block converts that code again. A period of zero switches refresh off.

Back-pressure rules: a word transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while the queue holds four words. A word offered while `in_ready` is low is not taken, and the source must present it again if it still wants it converted. The cell side has no back-pressure, and `cell_eoc` is a one-cycle pulse.

Top module: `dac_seq_ctrl`

## Requirements
- R1: `in_ready` is high exactly while the queue holds fewer than 4 words. A word (12-bit `in_data`, 1-bit `in_chan`, where 0 selects channel 0 and 1 selects channel 1) is taken on each edge with `in_valid` and `in_ready` high.
- R2: Queued words are converted in arrival order. Each conversion is a single-cycle `conv_start` pulse with `conv_chan`/`conv_data` equal to the word's tag and code, and it only occurs while `cell_en` is high.
- R3: After reset and whenever no queued word and no due refresh exist, `cell_en` is low. Pending work raises `cell_en` on the next edge.
- R4: The first `conv_start` after `cell_en` rises comes `cfg_startup`+1 cycles after the rise.
- R5: With `cfg_max_speed` low, the next conversion starts in the cycle after `cell_eoc`, and `eoc_flag` pulses one cycle after `cell_eoc`.
- R6: With `cfg_max_speed` high, `cell_eoc` does not affect sequencing. Back-to-back starts are 24 cycles apart (cell latency 25 minus 1), and `eoc_flag` pulses three cycles after `cell_eoc`.
- R7: When no work remains, `cell_en` falls two cycles after the cell's final `cell_eoc`, in either timing mode.
- R8: `cell_stby` is high exactly while `cell_en` is low and `cfg_fast_wake` is high.
- R9: A channel that has converted at least one code is converted again with its last code once `cfg_refresh` cycles have passed since its latest start. With `cfg_refresh` = 0 no refresh occurs.
- R10: A queued word goes before any refresh, and a channel 0 refresh goes before a channel 1 refresh.
- R11: A word offered while `in_ready` is low is never converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Conversion word offered |
| in_ready | output | 1 | Queue has space |
| in_data | input | 12 | Code to convert |
| in_chan | input | 1 | Target channel tag |
| cfg_startup | input | 8 | Start-up wait in cycles |
| cfg_fast_wake | input | 1 | Light standby while asleep |
| cfg_max_speed | input | 1 | Counter-timed conversions |
| cfg_refresh | input | 16 | Refresh period in cycles, 0 = off |
| cell_en | output | 1 | Cell fully powered |
| cell_stby | output | 1 | Cell in light standby |
| conv_start | output | 1 | One-cycle conversion strobe |
| conv_chan | output | 1 | Channel of the current strobe |
| conv_data | output | 12 | Code of the current strobe |
| cell_eoc | input | 1 | Cell end-of-cycle pulse |
| eoc_flag | output | 1 | End-of-conversion status pulse |

## Verification
Several input patterns are applied:
- A short burst of words on alternating channels shows queue order, tag routing and the wake, convert and sleep cycle.
- A burst longer than the queue while the cell wakes separates accepted words from refused ones.
- Runs with fast wake-up and with max-speed timing show the standby output, the shortened start spacing and the delayed status flag. A max-speed burst that ends the queue shows the power-down tail.
- A refresh period applied to both channels, with a word injected midway, tells queue priority apart from the channel order of refreshes. Setting the period back to zero must end the refresh traffic.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_ISSUE,
    ST_BUSY,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/dac_req_fifo.sv
module dac_req_fifo #(
  parameter int W = 13,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/dac_refresh_tracker.sv
module dac_refresh_tracker #(
  parameter int DATA_W = 12,
  parameter int NCH = 2,
  parameter int TMR_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue,
  input  logic                          issue_new,
  input  logic [CH_W-1:0]               issue_chan,
  input  logic [DATA_W-1:0]             issue_data,
  input  logic [TMR_W-1:0]              period,
  output logic [NCH-1:0]                due,
  output logic [NCH-1:0][DATA_W-1:0]    last_code
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TMR_W-1:0] age;
    logic             seen;
    logic             hit;

    assign hit    = issue && (issue_chan == CH_W'(c));
    assign due[c] = seen && (period != '0) && (age >= period);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age          <= '0;
        seen         <= 1'b0;
        last_code[c] <= '0;
      end else begin
        if (hit)             age <= '0;
        else if (age != '1)  age <= age + 1'b1;
        if (hit && issue_new) begin
          seen         <= 1'b1;
          last_code[c] <= issue_data;
        end
      end
    end
  end
endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int CELL_LAT = 25,
  parameter int START_W = 8,
  localparam int LAT_W = $clog2(CELL_LAT),
  localparam int CNT_W = (START_W > LAT_W) ? START_W : LAT_W,
  localparam int EARLY_LAST = CELL_LAT - 3,
  localparam int TAIL_LAST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               have_work,
  input  logic [START_W-1:0] cfg_startup,
  input  logic               cfg_max_speed,
  input  logic               cell_eoc,
  output logic               issue,
  output logic               cell_en,
  output logic               asleep,
  output logic               eoc_flag
);
  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       eoc_dly;

  assign issue    = (st == ST_ISSUE) && have_work;
  assign cell_en  = (st != ST_SLEEP);
  assign asleep   = (st == ST_SLEEP);
  assign eoc_flag = cfg_max_speed ? eoc_dly[2] : eoc_dly[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_SLEEP;
      cnt     <= '0;
      eoc_dly <= '0;
    end else begin
      eoc_dly <= {eoc_dly[1:0], cell_eoc};
      unique case (st)
        ST_SLEEP: if (have_work) begin
          st  <= ST_WAKE;
          cnt <= '0;
        end
        ST_WAKE: begin
          if (cnt >= CNT_W'(cfg_startup)) st <= ST_ISSUE;
          else                            cnt <= cnt + 1'b1;
        end
        ST_ISSUE: begin
          cnt <= '0;
          if (have_work)          st <= ST_BUSY;
          else if (cfg_max_speed) st <= ST_DRAIN;
          else                    st <= ST_SLEEP;
        end
        ST_BUSY: begin
          if (cfg_max_speed) begin
            if (cnt == CNT_W'(EARLY_LAST)) st <= ST_ISSUE;
            else                           cnt <= cnt + 1'b1;
          end else if (cell_eoc) begin
            st <= ST_ISSUE;
          end
        end
        ST_DRAIN: begin
          if (cnt == CNT_W'(TAIL_LAST)) st <= ST_SLEEP;
          else                          cnt <= cnt + 1'b1;
        end
        default: st <= ST_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl #(
  parameter int DATA_W = 12,
  parameter int NCH = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int START_W = 8,
  parameter int REF_W = 16,
  parameter int CELL_LAT = 25,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WORD_W = DATA_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [START_W-1:0] cfg_startup,
  input  logic              cfg_fast_wake,
  input  logic              cfg_max_speed,
  input  logic [REF_W-1:0]  cfg_refresh,
  output logic              cell_en,
  output logic              cell_stby,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic [DATA_W-1:0] conv_data,
  input  logic              cell_eoc,
  output logic              eoc_flag
);
  logic [WORD_W-1:0]             q_head;
  logic                          q_empty, q_full;
  logic [NCH-1:0]                ref_due;
  logic [NCH-1:0][DATA_W-1:0]    ref_code;
  logic                          sel_ok, sel_new, asleep;

  assign in_ready = !q_full;

  dac_req_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && !q_full), .push_word({in_chan, in_data}),
    .pop(conv_start && sel_new),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  always_comb begin
    sel_ok    = 1'b0;
    sel_new   = 1'b0;
    conv_chan = '0;
    conv_data = '0;
    if (!q_empty) begin
      sel_ok    = 1'b1;
      sel_new   = 1'b1;
      conv_chan = q_head[DATA_W +: CH_W];
      conv_data = q_head[DATA_W-1:0];
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (!sel_ok && ref_due[c]) begin
          sel_ok    = 1'b1;
          conv_chan = CH_W'(c);
          conv_data = ref_code[c];
        end
      end
    end
  end

  dac_refresh_tracker #(.DATA_W(DATA_W), .NCH(NCH), .TMR_W(REF_W)) u_refresh (
    .clk(clk), .rst_n(rst_n),
    .issue(conv_start), .issue_new(sel_new),
    .issue_chan(conv_chan), .issue_data(conv_data),
    .period(cfg_refresh), .due(ref_due), .last_code(ref_code)
  );

  dac_seq_fsm #(.CELL_LAT(CELL_LAT), .START_W(START_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .have_work(sel_ok), .cfg_startup(cfg_startup),
    .cfg_max_speed(cfg_max_speed), .cell_eoc(cell_eoc),
    .issue(conv_start), .cell_en(cell_en), .asleep(asleep),
    .eoc_flag(eoc_flag)
  );

  assign cell_stby = asleep && cfg_fast_wake;
endmodule

// File: rtl/dac_seq_ctrl_chk.sv
module dac_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_en,
  input logic cell_stby,
  input logic conv_start,
  input logic cfg_fast_wake,
  input logic cfg_max_speed,
  input logic cell_eoc,
  input logic eoc_flag
);
  assert_start_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> cell_en);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_wait_after_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_en) |-> !conv_start);

  assert_stby_only_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_stby |-> (!cell_en && cfg_fast_wake));

  assert_eoc_follows_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_eoc && !cfg_max_speed) |=> (eoc_flag || cfg_max_speed));
endmodule

bind dac_seq_ctrl dac_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .cell_stby(cell_stby),
  .conv_start(conv_start), .cfg_fast_wake(cfg_fast_wake),
  .cfg_max_speed(cfg_max_speed), .cell_eoc(cell_eoc), .eoc_flag(eoc_flag)
);

// File: tb/dac_seq_ctrl_tb_top.sv
module dac_seq_ctrl_tb_top;
  localparam int LAT = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        in_chan = 1'b0;
  logic [7:0]  cfg_startup = 8'd5;
  logic        cfg_fast_wake = 1'b0;
  logic        cfg_max_speed = 1'b0;
  logic [15:0] cfg_refresh = '0;
  logic        cell_en, cell_stby, conv_start, conv_chan, eoc_flag;
  logic [11:0] conv_data;
  logic        cell_eoc = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .cfg_startup(cfg_startup),
    .cfg_fast_wake(cfg_fast_wake), .cfg_max_speed(cfg_max_speed),
    .cfg_refresh(cfg_refresh), .cell_en(cell_en), .cell_stby(cell_stby),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_data(conv_data),
    .cell_eoc(cell_eoc), .eoc_flag(eoc_flag)
  );

  // reference model state
  int m_st = 0;   // 0 asleep, 1 waking, 2 choosing, 3 converting, 4 tail
  int m_cnt = 0;
  int m_q[$];     // {chan, data} as chan*4096 + data
  int m_last[2];
  bit m_seen[2];
  int m_age[2];
  bit m_d0, m_d1, m_d2;
  int cellq[$];

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_q.delete();
    for (int c = 0; c < 2; c++) begin
      m_last[c] = 0; m_seen[c] = 0; m_age[c] = 0;
    end
    m_d0 = 0; m_d1 = 0; m_d2 = 0;
  endtask

  initial model_reset();

  // monitor: cell responder, comparison and model step
  initial begin
    forever begin
      bit e_rdy, e_en, e_stby, e_start, e_flag, e_new;
      bit due[2];
      int e_chan, e_data;
      @(negedge clk);
      cyc++;
      cell_eoc = (cellq.size() > 0 && cellq[0] == cyc);
      if (cell_eoc) void'(cellq.pop_front());
      #1;
      e_rdy  = (m_q.size() < 4);
      e_en   = (m_st != 0);
      e_stby = cfg_fast_wake && (m_st == 0);
      for (int c = 0; c < 2; c++)
        due[c] = m_seen[c] && (cfg_refresh != 0) && (m_age[c] >= int'(cfg_refresh));
      e_new = 0; e_chan = 0; e_data = 0;
      e_start = 0;
      if (m_q.size() > 0) begin
        e_new = 1; e_chan = m_q[0] / 4096; e_data = m_q[0] % 4096;
      end else if (due[0]) begin
        e_chan = 0; e_data = m_last[0];
      end else if (due[1]) begin
        e_chan = 1; e_data = m_last[1];
      end
      e_start = (m_st == 2) && (e_new || due[0] || due[1]);
      e_flag = cfg_max_speed ? m_d2 : m_d0;

      check("R1/R11 in_ready", in_ready, e_rdy);
      check("R3/R7 cell_en", cell_en, e_en);
      check("R8 cell_stby", cell_stby, e_stby);
      check("R2/R4/R5/R6/R9/R10 conv_start", conv_start, e_start);
      check("R5/R6 eoc_flag", eoc_flag, e_flag);
      if (e_start && conv_start) begin
        check("R2/R9/R10 conv_chan", conv_chan, e_chan);
        check("R2/R9 conv_data", conv_data, e_data);
      end
      if (conv_start) cellq.push_back(cyc + LAT);

      if (!rst_n) begin
        model_reset();
      end else begin
        bit do_push;
        do_push = in_valid && e_rdy;
        if (e_start && e_new) void'(m_q.pop_front());
        if (do_push) m_q.push_back(int'(in_chan) * 4096 + int'(in_data));
        for (int c = 0; c < 2; c++) begin
          if (e_start && e_chan == c) m_age[c] = 0;
          else if (m_age[c] < 65535) m_age[c]++;
        end
        if (e_start && e_new) begin
          m_last[e_chan] = e_data; m_seen[e_chan] = 1;
        end
        m_d2 = m_d1; m_d1 = m_d0; m_d0 = cell_eoc;
        case (m_st)
          0: if (e_new || due[0] || due[1]) begin m_st = 1; m_cnt = 0; end
          1: if (m_cnt >= int'(cfg_startup)) m_st = 2; else m_cnt++;
          2: begin
            m_cnt = 0;
            if (e_start) m_st = 3;
            else if (cfg_max_speed) m_st = 4;
            else m_st = 0;
          end
          3: begin
            if (cfg_max_speed) begin
              if (m_cnt == LAT - 3) m_st = 2; else m_cnt++;
            end else if (cell_eoc) m_st = 2;
          end
          default: if (m_cnt == 1) m_st = 0; else m_cnt++;
        endcase
      end
    end
  end

  task automatic offer(input bit ch, input int data);
    @(negedge clk);
    in_valid = 1'b1;
    in_chan  = ch;
    in_data  = 12'(data);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 R2 R3 R4 R5 R7: short mixed-channel burst in normal timing
    offer(0, 'h123); offer(1, 'h456); offer(0, 'hABC);
    idle(120);
    // R11: burst longer than the queue while the cell wakes
    for (int i = 0; i < 6; i++) offer(i[0], 100 + i);
    idle(250);
    // R8: light standby while asleep, shorter start-up
    cfg_fast_wake = 1'b1; cfg_startup = 8'd2;
    idle(5);
    offer(1, 'hFFF); offer(0, 'h001);
    idle(100);
    // R6 R7: counter-timed conversions
    cfg_fast_wake = 1'b0; cfg_max_speed = 1'b1; cfg_startup = 8'd3;
    for (int i = 0; i < 5; i++) offer(i[0], 'h300 + i);
    idle(250);
    // R9 R10: periodic refresh, word injected midway
    cfg_max_speed = 1'b0; cfg_refresh = 16'd60;
    idle(400);
    offer(1, 'h7FF);
    idle(300);
    cfg_max_speed = 1'b1;
    idle(200);
    // R9: period zero stops refresh
    cfg_refresh = 16'd0;
    idle(150);
    finished = 1;
    summary();
  end
endmodule